// File: doc/BRIEF.md
# Descriptor-Chain Transmit Queue Engine

This block is the transmit side of one endpoint. It runs through a chain of linked 16-byte descriptors held in a word-addressed descriptor memory. Software loads that memory through a host port.

Each descriptor holds four 32-bit words, at byte offsets 0, 4, 8 and 12 from its base:

- offset 0: the flags word
- offset 4: the next-descriptor pointer
- offset 8: the buffer address
- offset 12: the length word

For each descriptor the engine checks a handshake bit that says the hardware owns it. It then streams the buffer as fixed-width beats, or skips the buffer when the descriptor is marked for bypass. Next it writes the flags word back with ownership cleared, and moves on to the descriptor named by the pointer.

When the engine reaches a descriptor that software has not handed over, it parks on that descriptor's address. It stays there until a resume command makes it fetch the descriptor again. Start, stop and resume commands drive the engine. A status flag, the current descriptor address and a completion pulse let the surrounding logic track progress.

Top module: `txq_engine`

## Requirements
- R1: After reset, q_active, desc_done and pkt_valid are low and cur_desc_addr is zero.
- R2: A cmd_start while inactive has two effects one cycle later: q_active is high, and cur_desc_addr equals start_addr with its low four bits forced to zero. Fetching then begins at that address.
- R3: A cmd_start while q_active is high is ignored; cur_desc_addr does not change.
- R4: A descriptor whose flags bit 0 (hardware owns) is clear is not processed. The engine holds cur_desc_addr on it, emits no beat and does no writeback. A resume that finds the bit still clear leaves the engine parked at the same address.
- R5: An owned descriptor with byte count N > 0 produces ceil(N/BEAT_BYTES) beats. The beat addresses step by BEAT_BYTES from the buffer address. Every beat carries BEAT_BYTES bytes except the last, which carries the remainder and has pkt_last set.
- R6: The byte count is the low 16 bits of the length word (the low 20 bits when EXT_LEN=1); the higher bits are ignored.
- R7: A byte count of zero with flags bit 6 set produces exactly one beat with pkt_bytes=0 and pkt_last=1. With bit 6 clear it produces no beat.
- R8: A descriptor with flags bit 2 (bypass) set produces no beat, but is still written back and followed.
- R9: Writeback rewrites the flags word with bit 0 cleared and all other bits unchanged. The next current address is the pointer word with its low four bits forced to zero.
- R10: desc_done pulses for one cycle, in the cycle after a writeback, and only when flags bit 7 of that descriptor was set.
- R11: cmd_stop takes effect only at a descriptor boundary. A descriptor being transferred completes and is written back. q_active then falls before the next descriptor is fetched. When the engine is parked, q_active falls in the next cycle.
- R12: cmd_resume while parked re-fetches the descriptor at cur_desc_addr; if it is now owned, it is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start command (one-cycle pulse) |
| cmd_stop | input | 1 | Stop command (one-cycle pulse) |
| cmd_resume | input | 1 | Resume command (one-cycle pulse) |
| start_addr | input | ADDR_W | Byte address of the first descriptor |
| q_active | output | 1 | Engine is running or parked |
| cur_desc_addr | output | ADDR_W | Byte address of the current descriptor |
| desc_done | output | 1 | Completion pulse for descriptors with bit 7 set |
| pkt_valid | output | 1 | Packet beat present |
| pkt_addr | output | 32 | Buffer byte address of the beat |
| pkt_bytes | output | BCNT_W | Bytes carried by the beat |
| pkt_last | output | 1 | Final beat of the packet |
| host_en | input | 1 | Host memory port enable |
| host_we | input | 1 | Host write enable |
| host_addr | input | ADDR_W-2 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after host_en |

## Verification
The assertions check these properties on every cycle:

- Beat shape: full beats before the last, consecutive beat addresses, and zero-byte beats always last.
- The address loaded by a start, and a start while active leaving the address untouched.
- The held address while parked.
- The completion pulse matching a writeback of a descriptor with bit 7 set.
- q_active only ever falling at a descriptor boundary.

Some behaviour only the bench scenarios can show. These are:

- the exact beat contents per descriptor, including a length word with garbage upper bits
- bypass and zero-length descriptors
- the flags word read back after writeback
- an unaligned next pointer
- a stop issued in the middle of a transfer leaving the following owned descriptor untouched in memory

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int FLG_OWN = 0;
  localparam int FLG_BYP = 2;
  localparam int FLG_ZLP = 6;
  localparam int FLG_IOC = 7;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_XFER,
    W_WB,
    W_PARK
  } walk_st_t;
endpackage

// File: rtl/txq_desc_mem.sv
module txq_desc_mem #(
  parameter int WIX_W = 10,
  localparam int DEPTH = 1 << WIX_W
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [WIX_W-1:0] a_addr,
  input  logic [31:0]      a_wdata,
  output logic [31:0]      a_rdata,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [WIX_W-1:0] b_addr,
  input  logic [31:0]      b_wdata,
  output logic [31:0]      b_rdata
);
  logic [31:0] ram [DEPTH];

  // two registered read ports; engine write is last so it wins a same-word clash
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) ram[a_addr] <= a_wdata;
      a_rdata <= ram[a_addr];
    end
    if (b_en) begin
      if (b_we) ram[b_addr] <= b_wdata;
      b_rdata <= ram[b_addr];
    end
  end
endmodule

// File: rtl/txq_beat_gen.sv
module txq_beat_gen #(
  parameter int LEN_W = 16,
  parameter int BEAT_BYTES = 8,
  localparam int BCNT_W = $clog2(BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [31:0]       base,
  input  logic [LEN_W-1:0]  len,
  input  logic              zlp,
  output logic              out_valid,
  output logic [31:0]       out_addr,
  output logic [BCNT_W-1:0] out_bytes,
  output logic              out_last,
  output logic              fin
);
  localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);

  logic             running;
  logic [LEN_W-1:0] rem;
  logic [31:0]      ptr;
  logic             zf;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      rem       <= '0;
      ptr       <= '0;
      zf        <= 1'b0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_bytes <= '0;
      out_last  <= 1'b0;
      fin       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      fin       <= 1'b0;
      if (go) begin
        running <= 1'b1;
        rem     <= len;
        ptr     <= base;
        zf      <= zlp;
      end else if (running) begin
        out_addr <= ptr;
        if (rem == '0) begin
          running   <= 1'b0;
          fin       <= 1'b1;
          out_valid <= zf;
          out_bytes <= '0;
          out_last  <= zf;
        end else if (rem <= BEAT_L) begin
          running   <= 1'b0;
          fin       <= 1'b1;
          out_valid <= 1'b1;
          out_bytes <= BCNT_W'(rem);
          out_last  <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_bytes <= BCNT_W'(BEAT_BYTES);
          rem       <= rem - BEAT_L;
          ptr       <= ptr + 32'(BEAT_BYTES);
        end
      end
    end
  end

  p_full_beat_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_bytes == BCNT_W'(BEAT_BYTES)));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && out_addr == $past(out_addr) + 32'(BEAT_BYTES)));
  p_zero_last_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bytes == '0) |-> out_last);
endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter bit EXT_LEN = 1'b0,
  localparam int LEN_W = EXT_LEN ? 20 : 16,
  localparam int WIX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              active,
  output logic [ADDR_W-1:0] cur,
  output logic              done,
  output logic              m_en,
  output logic              m_we,
  output logic [WIX_W-1:0]  m_addr,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  output logic              bg_go,
  output logic [31:0]       bg_base,
  output logic [LEN_W-1:0]  bg_len,
  output logic              bg_zlp,
  input  logic              bg_fin
);
  localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(15);

  walk_st_t          st;
  logic [2:0]        cnt;
  logic [31:0]       w_flags;
  logic [ADDR_W-1:0] w_next;
  logic [31:0]       w_buf;
  logic              stop_pend;
  logic [LEN_W-1:0]  len_f;

  generate
    if (EXT_LEN) begin : g_len_ext
      assign len_f = m_rdata[19:0];
    end else begin : g_len_std
      assign len_f = m_rdata[15:0];
    end
  endgenerate

  always_comb begin
    m_en    = (st == W_FETCH && cnt < 3'd4) || (st == W_WB);
    m_we    = (st == W_WB);
    m_addr  = {cur[ADDR_W-1:4], (st == W_FETCH) ? cnt[1:0] : 2'd0};
    m_wdata = w_flags & ~32'd1;
    bg_go   = (st == W_FETCH) && (cnt == 3'd4) && !w_flags[FLG_BYP];
    bg_base = w_buf;
    bg_len  = len_f;
    bg_zlp  = w_flags[FLG_ZLP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      cnt       <= '0;
      active    <= 1'b0;
      cur       <= '0;
      done      <= 1'b0;
      w_flags   <= '0;
      w_next    <= '0;
      w_buf     <= '0;
      stop_pend <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_stop && active) stop_pend <= 1'b1;
      case (st)
        W_IDLE: begin
          if (cmd_start) begin
            cur       <= start_addr & ALIGN;
            active    <= 1'b1;
            stop_pend <= 1'b0;
            cnt       <= '0;
            st        <= W_FETCH;
          end
        end
        W_FETCH: begin
          case (cnt)
            3'd0: begin
              if (stop_pend) begin
                st        <= W_IDLE;
                active    <= 1'b0;
                stop_pend <= 1'b0;
              end else begin
                cnt <= 3'd1;
              end
            end
            3'd1: begin
              w_flags <= m_rdata;
              if (!m_rdata[FLG_OWN]) begin
                st  <= W_PARK;
                cnt <= '0;
              end else begin
                cnt <= 3'd2;
              end
            end
            3'd2: begin
              w_next <= m_rdata[ADDR_W-1:0] & ALIGN;
              cnt    <= 3'd3;
            end
            3'd3: begin
              w_buf <= m_rdata;
              cnt   <= 3'd4;
            end
            default: begin
              cnt <= '0;
              st  <= w_flags[FLG_BYP] ? W_WB : W_XFER;
            end
          endcase
        end
        W_XFER: begin
          if (bg_fin) st <= W_WB;
        end
        W_WB: begin
          cur  <= w_next;
          done <= w_flags[FLG_IOC];
          cnt  <= '0;
          st   <= W_FETCH;
        end
        W_PARK: begin
          if (stop_pend || cmd_stop) begin
            st        <= W_IDLE;
            active    <= 1'b0;
            stop_pend <= 1'b0;
          end else if (cmd_resume) begin
            cnt <= '0;
            st  <= W_FETCH;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && st == W_IDLE) |=> (active && cur == ($past(start_addr) & ALIGN)));
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && active && st != W_WB) |=> $stable(cur));
  p_park_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st == W_PARK) |=> $stable(cur));
  p_done_after_wb_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st == W_WB && w_flags[FLG_IOC]));
  p_stop_boundary_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(st == W_PARK || (st == W_FETCH && cnt == 3'd0)));
endmodule

// File: rtl/txq_engine.sv
module txq_engine #(
  parameter int ADDR_W = 12,
  parameter int BEAT_BYTES = 8,
  parameter bit EXT_LEN = 1'b0,
  localparam int LEN_W = EXT_LEN ? 20 : 16,
  localparam int WIX_W = ADDR_W - 2,
  localparam int BCNT_W = $clog2(BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              q_active,
  output logic [ADDR_W-1:0] cur_desc_addr,
  output logic              desc_done,
  output logic              pkt_valid,
  output logic [31:0]       pkt_addr,
  output logic [BCNT_W-1:0] pkt_bytes,
  output logic              pkt_last,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [WIX_W-1:0]  host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata
);
  logic             m_en, m_we;
  logic [WIX_W-1:0] m_addr;
  logic [31:0]      m_wdata, m_rdata;
  logic             bg_go, bg_zlp, bg_fin;
  logic [31:0]      bg_base;
  logic [LEN_W-1:0] bg_len;

  txq_desc_mem #(.WIX_W(WIX_W)) u_mem (
    .clk(clk),
    .a_en(host_en), .a_we(host_we), .a_addr(host_addr),
    .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_en(m_en), .b_we(m_we), .b_addr(m_addr),
    .b_wdata(m_wdata), .b_rdata(m_rdata)
  );

  txq_walker #(.ADDR_W(ADDR_W), .EXT_LEN(EXT_LEN)) u_walk (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume),
    .start_addr(start_addr),
    .active(q_active), .cur(cur_desc_addr), .done(desc_done),
    .m_en(m_en), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata),
    .bg_go(bg_go), .bg_base(bg_base), .bg_len(bg_len),
    .bg_zlp(bg_zlp), .bg_fin(bg_fin)
  );

  txq_beat_gen #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_beat (
    .clk(clk), .rst(rst),
    .go(bg_go), .base(bg_base), .len(bg_len), .zlp(bg_zlp),
    .out_valid(pkt_valid), .out_addr(pkt_addr),
    .out_bytes(pkt_bytes), .out_last(pkt_last),
    .fin(bg_fin)
  );

  p_pkt_needs_active_r11: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> q_active);
endmodule

// File: tb/tb_txq_engine.sv
module tb_txq_engine;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic q_active, desc_done, pkt_valid, pkt_last;
  logic [ADDR_W-1:0] cur_desc_addr;
  logic [31:0] pkt_addr;
  logic [3:0]  pkt_bytes;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [ADDR_W-3:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  always #10 clk = ~clk;

  txq_engine dut (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume),
    .start_addr(start_addr),
    .q_active(q_active), .cur_desc_addr(cur_desc_addr), .desc_done(desc_done),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_bytes(pkt_bytes), .pkt_last(pkt_last),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  b;
    logic        l;
  } beat_t;

  beat_t exp_q[$];
  string tag_q[$];
  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && desc_done) done_cnt++;
    if (!rst && pkt_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected beat addr", pkt_addr, 32'hffff_ffff);
      end else begin
        beat_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pkt_addr == e.a && pkt_bytes == e.b && pkt_last == e.l, t,
            "beat {addr,bytes,last}", {pkt_addr[26:0], pkt_bytes, pkt_last},
            {e.a[26:0], e.b, e.l});
      end
    end
  end

  task automatic expect_xfer(input logic [31:0] buf_a, input logic [31:0] lenw,
                             input bit zlp, input string tag);
    int n;
    logic [31:0] p;
    n = int'(lenw & 32'h0000_ffff);
    p = buf_a;
    if (n == 0) begin
      if (zlp) begin
        exp_q.push_back('{a: p, b: 4'd0, l: 1'b1});
        tag_q.push_back(tag);
      end
    end else begin
      while (n > 0) begin
        exp_q.push_back('{a: p, b: (n > 8) ? 4'd8 : 4'(n), l: (n <= 8)});
        tag_q.push_back(tag);
        n -= 8;
        p += 8;
      end
    end
  endtask

  task automatic hwrite(input logic [ADDR_W-1:0] byte_a, input logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = byte_a[ADDR_W-1:2]; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [ADDR_W-1:0] byte_a, output logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = byte_a[ADDR_W-1:2];
    @(negedge clk);
    host_en = 1'b0;
    d = host_rdata;
  endtask

  // flags word written last, as software would
  task automatic put_desc(input logic [ADDR_W-1:0] a, input logic [31:0] flags,
                          input logic [31:0] nxt, input logic [31:0] bufa,
                          input logic [31:0] lenw);
    hwrite(a + 4, nxt);
    hwrite(a + 8, bufa);
    hwrite(a + 12, lenw);
    hwrite(a, flags);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1'b1;
    else if (which == 1) cmd_stop = 1'b1;
    else cmd_resume = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0; cmd_resume = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_flags(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                             input string req);
    logic [31:0] d;
    hread(a, d);
    chk(d == exp, req, "flags word after walk", d, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(q_active == 1'b0, "R1", "q_active", 32'(q_active), 0);
    chk(pkt_valid == 1'b0, "R1", "pkt_valid", 32'(pkt_valid), 0);
    chk(desc_done == 1'b0, "R1", "desc_done", 32'(desc_done), 0);
    chk(cur_desc_addr == '0, "R1", "cur_desc_addr", 32'(cur_desc_addr), 0);

    // chain: D0 normal (R5), D1 garbage upper length (R6), D2 bypass (R8),
    // D3 zero-length with zlp (R7), D4 zero-length no zlp, unaligned next (R9), D5 unowned (R4)
    put_desc(12'h000, 32'h81, 32'h10, 32'h1000, 32'd20);
    put_desc(12'h010, 32'h01, 32'h20, 32'h2000, 32'h0003_0008);
    put_desc(12'h020, 32'h85, 32'h30, 32'h7000, 32'd16);
    put_desc(12'h030, 32'hC1, 32'h40, 32'h3000, 32'd0);
    put_desc(12'h040, 32'h01, 32'h5C, 32'h3800, 32'd0);
    hwrite(12'h050, 32'h0);
    expect_xfer(32'h1000, 32'd20, 1'b0, "R5");
    expect_xfer(32'h2000, 32'h0003_0008, 1'b0, "R6");
    expect_xfer(32'h3000, 32'd0, 1'b1, "R7");

    start_addr = 12'h003;
    pulse(0);
    // R2: active and aligned address one cycle after the start
    chk(q_active == 1'b1, "R2", "q_active after start", 32'(q_active), 1);
    chk(cur_desc_addr == 12'h000, "R2", "cur after start", 32'(cur_desc_addr), 0);
    idle(200);
    chk(exp_q.size() == 0, "R5", "beats left over", exp_q.size(), 0);
    chk(cur_desc_addr == 12'h050, "R4", "park address", 32'(cur_desc_addr), 32'h50);
    chk(q_active == 1'b1, "R4", "active while parked", 32'(q_active), 1);
    chk(done_cnt == 3, "R10", "done pulses", done_cnt, 3);
    check_flags(12'h000, 32'h80, "R9");
    check_flags(12'h010, 32'h00, "R9");
    check_flags(12'h020, 32'h84, "R8");
    check_flags(12'h030, 32'hC0, "R9");
    check_flags(12'h040, 32'h00, "R9");
    check_flags(12'h050, 32'h00, "R4");

    // R3: start while active is ignored
    start_addr = 12'h200;
    pulse(0);
    idle(20);
    chk(cur_desc_addr == 12'h050, "R3", "cur after ignored start", 32'(cur_desc_addr), 32'h50);
    chk(exp_q.size() == 0, "R3", "no beats from ignored start", exp_q.size(), 0);

    // R12: hand D5 over and resume
    put_desc(12'h050, 32'h81, 32'h60, 32'h4000, 32'd3);
    hwrite(12'h060, 32'h0);
    chk(cur_desc_addr == 12'h050, "R4", "still parked before resume", 32'(cur_desc_addr), 32'h50);
    expect_xfer(32'h4000, 32'd3, 1'b0, "R12");
    pulse(2);
    idle(100);
    chk(cur_desc_addr == 12'h060, "R12", "cur after resume", 32'(cur_desc_addr), 32'h60);
    chk(done_cnt == 4, "R12", "done pulses after resume", done_cnt, 4);
    chk(exp_q.size() == 0, "R12", "beats left over", exp_q.size(), 0);
    check_flags(12'h050, 32'h80, "R12");

    // R4: resume with the descriptor still unowned keeps parking
    pulse(2);
    idle(50);
    chk(cur_desc_addr == 12'h060, "R4", "cur after futile resume", 32'(cur_desc_addr), 32'h60);
    chk(done_cnt == 4, "R4", "no done after futile resume", done_cnt, 4);

    // R11: stop while parked drops active on the next cycle
    pulse(1);
    chk(q_active == 1'b0, "R11", "active after parked stop", 32'(q_active), 0);
    chk(cur_desc_addr == 12'h060, "R11", "cur after parked stop", 32'(cur_desc_addr), 32'h60);

    // R11: stop during a transfer finishes it and does not touch the next owned one
    put_desc(12'h060, 32'h81, 32'h70, 32'h5000, 32'd40);
    put_desc(12'h070, 32'h81, 32'h80, 32'h6000, 32'd8);
    expect_xfer(32'h5000, 32'd40, 1'b0, "R11");
    start_addr = 12'h060;
    pulse(0);
    chk(q_active == 1'b1, "R2", "active after restart", 32'(q_active), 1);
    idle(4);
    pulse(1);
    idle(200);
    chk(q_active == 1'b0, "R11", "active after stop", 32'(q_active), 0);
    chk(cur_desc_addr == 12'h070, "R11", "cur after stop", 32'(cur_desc_addr), 32'h70);
    chk(done_cnt == 5, "R10", "done pulses after stop", done_cnt, 5);
    chk(exp_q.size() == 0, "R11", "beats left over", exp_q.size(), 0);
    check_flags(12'h060, 32'h80, "R11");
    check_flags(12'h070, 32'h81, "R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule